// File: doc/BRIEF.md
# Command-Queue SPI Master

This block is an SPI bus master driven by a small queue of 32-bit command words. Software writes command words into a transmit FIFO. Each word holds one data frame and the control that applies to that frame: which chip-select lines to assert, which attribute set to use, whether chip select stays asserted after the frame, whether the frame ends the queue, and whether the frame counter restarts. A serial engine takes one word at a time. It shifts the frame out on `mosi_o` and captures the bits on `miso_i` at the same time. Each received frame goes into a receive FIFO, which software drains through a pop register.

Each attribute register holds a frame length of 4 to 16 bits, the clock polarity, the clock phase, the bit order and a half-period divider. A frame marked as end of queue sets a status flag when it completes. That flag can raise the interrupt. The queue stays halted until software writes the flag to clear it, so software can refill and restart the queue in controlled batches.

Register word addresses are 0x0 control, 0x1 status, 0x2 interrupt enable, 0x3 push, 0x4 pop and 0x8+k attribute set k. Read data is combinational. A pop takes effect at the clock edge on which `reg_rd` is sampled.

Top module: `cmdq_spi_master`

## Requirements
- R1: After reset, `cs_o` equals the inactive level (all ones), `sck_o` and `irq` are 0, the status word reads 0 and the control register reads 0x3F00.
- R2: The push word carries data in [15:0], one-hot chip-select lines in [21:16], counter clear in [26], end of queue in [27], attribute set in [30:28] (only the low log2 of the number of attribute sets bits are used) and continuous select in [31]. The frame length is the attribute field [3:0] plus one, and values below 3 are treated as 3. By default the most significant bit is shifted first.
- R3: Attribute bit [4] is the clock polarity and bit [5] is the clock phase. With phase 0, data is sampled on the leading clock edge; with phase 1, on the trailing edge. Each half clock period lasts attribute field [11:8] plus one cycles. Between frames, `sck_o` rests at the polarity of the most recent frame, or at 0 if no frame has run since reset.
- R4: When attribute bit [6] is set, frames are transmitted and received least significant bit first.
- R5: Every completed frame places its received bits, right-aligned, into the receive FIFO (4 entries). A read of the pop register returns the oldest entry in [15:0] and removes it.
- R6: When a frame marked end of queue completes, status bit [0] is set. Writing 1 to that bit clears it. If a set and a clear fall in the same cycle, the set wins. `irq` equals that flag ANDed with interrupt-enable bit [0]. While the flag is set, no word is taken from the transmit FIFO.
- R7: A frame with the continuous bit set keeps its chip select asserted until the next frame starts. Otherwise chip select returns to the inactive level when the frame ends. An asserted line is the inverse of its inactive level.
- R8: Status [31:16] counts completed frames. A word with the counter-clear bit set resets the count to 0 when its frame starts.
- R9: A push to a full transmit FIFO (4 entries), or a pop from an empty receive FIFO, leaves that FIFO unchanged and sets the sticky error bit, status [1]. Writing 1 to status [1] clears it. Status [7:4] holds the transmit FIFO level and [11:8] holds the receive FIFO level.
- R10: Writing 1 to control bit [16] empties the transmit FIFO, and writing 1 to bit [17] empties the receive FIFO. Both bits read back as 0.
- R11: Control bit [0] enables the engine. While it is 0, no frame starts and queued words stay in the transmit FIFO. Control [13:8] holds the inactive chip-select levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of the pop register removes an entry) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | End-of-queue interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NCS | Chip-select lines |

## Verification
Two functions can fall in the same cycle: the engine setting the end-of-queue flag when an end-of-queue frame completes, and a software write-one-to-clear of that flag. To provoke this, the bench watches `sck_o` until the last sample edge of an 8-bit frame with a one-cycle half period. It then issues the clearing write so that the write lands on the exact clock edge on which the frame completes. The bench judges the result by reading the status word afterwards: the flag must still be set, because the set has priority.

// File: rtl/cmdq_spi_pkg.sv
package cmdq_spi_pkg;

   localparam logic [3:0] A_CTRL  = 4'h0;
   localparam logic [3:0] A_STAT  = 4'h1;
   localparam logic [3:0] A_IRQEN = 4'h2;
   localparam logic [3:0] A_PUSH  = 4'h3;
   localparam logic [3:0] A_POP   = 4'h4;

   // attribute set: frame length, clock shape, bit order, divider
   typedef struct packed {
      logic [3:0] hdiv;
      logic       lsb;
      logic       cpha;
      logic       cpol;
      logic [3:0] fsz;
   } attr_t;

   // transmit command word as pushed by software
   typedef struct packed {
      logic        cont;
      logic [2:0]  asel;
      logic        eoq;
      logic        clr_cnt;
      logic [3:0]  rsvd;
      logic [5:0]  pcs;
      logic [15:0] data;
   } cmd_t;

endpackage

// File: rtl/cmdq_spi_fifo.sv
module cmdq_spi_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic                       full,
   output logic                       empty,
   output logic [$clog2(DEPTH):0]     level
);
   localparam int PW = $clog2(DEPTH);
   localparam int LW = PW + 1;

   if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
      $error("cmdq_spi_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= wdata;
   end

endmodule

// File: rtl/cmdq_spi_shifter.sv
module cmdq_spi_shifter
   import cmdq_spi_pkg::*;
#(
   parameter int NCS = 6
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  cmd_t           cmd,
   input  attr_t          attr,
   input  logic           miso,
   output logic           busy,
   output logic           done,
   output logic           done_eoq,
   output logic           sck,
   output logic           mosi,
   output logic [15:0]    rx_word,
   output logic [NCS-1:0] sel_lines
);
   logic [4:0]     h;
   logic [3:0]     tmr, nb, hdiv_q;
   logic [15:0]    txs, rxs, rx_ins, mask;
   logic           cpol_q, cpha_q, lsb_q, eoq_q, cont_q, held;
   logic [NCS-1:0] pcs_q;
   logic           tick, last;

   assign tick     = busy && (tmr == hdiv_q);
   assign last     = (h == {nb, 1'b1});
   assign done     = tick && last;
   assign done_eoq = done && eoq_q;

   always_comb begin
      rx_ins     = rxs >> 1;
      rx_ins[nb] = miso;
      for (int i = 0; i < 16; i++) mask[i] = (i <= int'(nb));
   end

   assign rx_word   = rxs & mask;
   assign sck       = cpol_q ^ (busy & (cpha_q ^ h[0]));
   assign mosi      = busy & (lsb_q ? txs[0] : txs[nb]);
   assign sel_lines = (busy || held) ? pcs_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         held   <= 1'b0;
         h      <= '0;
         tmr    <= '0;
         nb     <= 4'd7;
         hdiv_q <= '0;
         txs    <= '0;
         rxs    <= '0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         lsb_q  <= 1'b0;
         eoq_q  <= 1'b0;
         cont_q <= 1'b0;
         pcs_q  <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         held   <= 1'b0;
         h      <= '0;
         tmr    <= '0;
         nb     <= (attr.fsz < 4'd3) ? 4'd3 : attr.fsz;
         hdiv_q <= attr.hdiv;
         txs    <= cmd.data;
         rxs    <= '0;
         cpol_q <= attr.cpol;
         cpha_q <= attr.cpha;
         lsb_q  <= attr.lsb;
         eoq_q  <= cmd.eoq;
         cont_q <= cmd.cont;
         pcs_q  <= cmd.pcs[NCS-1:0];
      end else if (busy) begin
         if (tick) begin
            tmr <= '0;
            h   <= h + 1'b1;
            if (!h[0]) begin
               rxs <= lsb_q ? rx_ins : {rxs[14:0], miso};
            end else if (last) begin
               busy <= 1'b0;
               held <= cont_q;
            end else begin
               txs <= lsb_q ? (txs >> 1) : (txs << 1);
            end
         end else begin
            tmr <= tmr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cmdq_spi_master.sv
module cmdq_spi_master
   import cmdq_spi_pkg::*;
#(
   parameter int NCS        = 6,
   parameter int FIFO_DEPTH = 4,
   parameter int NUM_ATTR   = 4,
   parameter int CNT_W      = 16
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic           reg_rd,
   input  logic [3:0]     reg_addr,
   input  logic [31:0]    reg_wdata,
   output logic [31:0]    reg_rdata,
   output logic           irq,
   output logic           sck_o,
   output logic           mosi_o,
   input  logic           miso_i,
   output logic [NCS-1:0] cs_o
);
   localparam int LW   = $clog2(FIFO_DEPTH) + 1;
   localparam int AS_W = $clog2(NUM_ATTR);

   if (NCS < 1 || NCS > 6) begin : g_bad_ncs
      $error("cmdq_spi_master: NCS must be 1..6");
   end
   if (NUM_ATTR < 2 || NUM_ATTR > 8 || (1 << AS_W) != NUM_ATTR) begin : g_bad_attr
      $error("cmdq_spi_master: NUM_ATTR must be a power of two in 2..8");
   end
   if (LW > 4) begin : g_bad_depth
      $error("cmdq_spi_master: FIFO_DEPTH must not exceed 8");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("cmdq_spi_master: CNT_W must be 1..16");
   end

   logic           run_q, irq_en, eoq_flag, err_flag;
   logic [NCS-1:0] idle;
   logic [CNT_W-1:0] frame_cnt;
   attr_t          attr_q [NUM_ATTR];
   logic [NUM_ATTR-1:0] attr_we;

   logic wr_ctrl, wr_stat, push_req, pop_req, flush_tx, flush_rx, attr_hit;
   logic start, busy, done, done_eoq;
   logic tx_full, tx_empty, rx_full, rx_empty;
   logic [LW-1:0]  tx_level, rx_level;
   logic [31:0]    tx_rdata;
   logic [15:0]    rx_rdata, rx_word;
   logic [NCS-1:0] sel_lines;
   cmd_t           cmd;

   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign wr_stat  = reg_wr && (reg_addr == A_STAT);
   assign push_req = reg_wr && (reg_addr == A_PUSH);
   assign pop_req  = reg_rd && (reg_addr == A_POP);
   assign flush_tx = wr_ctrl && reg_wdata[16];
   assign flush_rx = wr_ctrl && reg_wdata[17];
   assign attr_hit = reg_addr[3] && (int'(reg_addr[2:0]) < NUM_ATTR);

   for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr_we
      assign attr_we[k] = reg_wr && attr_hit && (reg_addr[AS_W-1:0] == AS_W'(k));
   end

   assign cmd   = cmd_t'(tx_rdata);
   assign start = run_q && !eoq_flag && !tx_empty && !busy && !flush_tx;

   cmdq_spi_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush_tx), .push(push_req),
      .wdata(reg_wdata), .pop(start), .rdata(tx_rdata),
      .full(tx_full), .empty(tx_empty), .level(tx_level)
   );

   cmdq_spi_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush_rx), .push(done),
      .wdata(rx_word), .pop(pop_req), .rdata(rx_rdata),
      .full(rx_full), .empty(rx_empty), .level(rx_level)
   );

   cmdq_spi_shifter #(.NCS(NCS)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
      .attr(attr_q[cmd.asel[AS_W-1:0]]), .miso(miso_i),
      .busy(busy), .done(done), .done_eoq(done_eoq),
      .sck(sck_o), .mosi(mosi_o), .rx_word(rx_word), .sel_lines(sel_lines)
   );

   for (genvar i = 0; i < NCS; i++) begin : g_cs
      assign cs_o[i] = idle[i] ^ sel_lines[i];
   end

   assign irq = eoq_flag & irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         idle      <= '1;
         irq_en    <= 1'b0;
         eoq_flag  <= 1'b0;
         err_flag  <= 1'b0;
         frame_cnt <= '0;
         for (int k = 0; k < NUM_ATTR; k++) attr_q[k] <= attr_t'{hdiv: 4'd0, lsb: 1'b0, cpha: 1'b0, cpol: 1'b0, fsz: 4'd7};
      end else begin
         if (wr_ctrl) begin
            run_q <= reg_wdata[0];
            idle  <= reg_wdata[8 +: NCS];
         end
         if (reg_wr && reg_addr == A_IRQEN) irq_en <= reg_wdata[0];
         for (int k = 0; k < NUM_ATTR; k++) begin
            if (attr_we[k]) attr_q[k] <= attr_t'{hdiv: reg_wdata[11:8], lsb: reg_wdata[6],
                                                cpha: reg_wdata[5], cpol: reg_wdata[4], fsz: reg_wdata[3:0]};
         end
         if (done_eoq)                    eoq_flag <= 1'b1;
         else if (wr_stat && reg_wdata[0]) eoq_flag <= 1'b0;
         if ((push_req && tx_full) || (pop_req && rx_empty) || (done && rx_full)) err_flag <= 1'b1;
         else if (wr_stat && reg_wdata[1]) err_flag <= 1'b0;
         if (start && cmd.clr_cnt) frame_cnt <= '0;
         else if (done)            frame_cnt <= frame_cnt + 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[0]        = run_q;
            reg_rdata[8 +: NCS] = idle;
         end
         A_STAT: begin
            reg_rdata[0]          = eoq_flag;
            reg_rdata[1]          = err_flag;
            reg_rdata[4 +: LW]    = tx_level;
            reg_rdata[8 +: LW]    = rx_level;
            reg_rdata[16 +: CNT_W] = frame_cnt;
         end
         A_IRQEN: reg_rdata[0]     = irq_en;
         A_POP:   reg_rdata[15:0]  = rx_rdata;
         default: begin
            if (attr_hit) begin
               reg_rdata[11:0] = {attr_q[reg_addr[AS_W-1:0]].hdiv, 1'b0,
                                  attr_q[reg_addr[AS_W-1:0]].lsb,
                                  attr_q[reg_addr[AS_W-1:0]].cpha,
                                  attr_q[reg_addr[AS_W-1:0]].cpol,
                                  attr_q[reg_addr[AS_W-1:0]].fsz};
            end
         end
      endcase
   end

endmodule

// File: rtl/cmdq_spi_chk.sv
module cmdq_spi_chk #(
   parameter int LW    = 3,
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             done_eoq,
   input logic             eoq_flag,
   input logic             err_flag,
   input logic             push_req,
   input logic             pop_req,
   input logic             tx_full,
   input logic             rx_empty,
   input logic             sck_o,
   input logic [LW-1:0]    tx_level,
   input logic [CNT_W-1:0] frame_cnt
);
   // R6: a pending end-of-queue flag halts the queue
   p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eoq_flag |-> !start);

   // R6: completion of an end-of-queue frame leaves the flag set
   p_eoq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_eoq |=> eoq_flag);

   // R9: push into a full queue does not change its level
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && tx_full && !start |=> tx_level == $past(tx_level));

   // R9: pop from an empty receive queue raises the error bit
   p_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req && rx_empty |=> err_flag);

   // R8: each completed frame advances the counter by one
   p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> frame_cnt == CNT_W'($past(frame_cnt) + 1'b1));

   // R3: the serial clock rests while no frame is running or starting
   p_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> $stable(sck_o));
endmodule

bind cmdq_spi_master cmdq_spi_chk #(.LW(LW), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .done_eoq(done_eoq), .eoq_flag(eoq_flag), .err_flag(err_flag),
   .push_req(push_req), .pop_req(pop_req), .tx_full(tx_full),
   .rx_empty(rx_empty), .sck_o(sck_o), .tx_level(tx_level),
   .frame_cnt(frame_cnt)
);

// File: tb/tb_cmdq_spi_master.sv
module tb_cmdq_spi_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, sck_o, mosi_o, miso_i;
   logic [5:0]  cs_o;
   logic        inv = 1'b0;

   always #10 clk = ~clk;
   assign miso_i = mosi_o ^ inv;

   cmdq_spi_master dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o)
   );

   int errors = 0, checks = 0, cyc = 0;

   // slave-side monitor on line 0
   logic        mon_cpol = 1'b0, mon_cpha = 1'b0;
   int          mon_cnt = 0, mon_asserts = 0;
   logic [15:0] mon_raw = '0;
   logic        p_sck = 1'b0, p_act = 1'b0;

   always @(negedge clk) begin
      logic act;
      act = rst_n && (cs_o[0] == 1'b0);
      if (act && !p_act) mon_asserts++;
      if (act && p_act && sck_o != p_sck && ((sck_o != mon_cpol) ^ mon_cpha)) begin
         mon_raw = {mon_raw[14:0], mosi_o};
         mon_cnt++;
      end
      p_sck = sck_o;
      p_act = act;
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(posedge clk); #1;
      reg_rd = 1'b1; reg_addr = a;
      #5 d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic wait_eoq();
      logic [31:0] s;
      for (int i = 0; i < 2000; i++) begin
         rd(4'h1, s);
         if (s[0]) return;
      end
      chk("R6 eoq flag never set", 32'd0, 32'd1);
   endtask

   function automatic logic [15:0] rev(input logic [15:0] v, input int n);
      logic [15:0] r = '0;
      for (int i = 0; i < n; i++) r[i] = v[n-1-i];
      return r;
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 cs idle", {26'b0, cs_o}, 32'h3F);
      chk("R1 sck", {31'b0, sck_o}, 32'd0);
      chk("R1 irq", {31'b0, irq}, 32'd0);
      rd(4'h1, d); chk("R1 status", d, 32'd0);
      rd(4'h0, d); chk("R1 control", d, 32'h3F00);
   endtask

   task automatic t_basic();
      logic [31:0] d;
      wr(4'h8, 32'h7);
      wr(4'h0, 32'h3F01);
      mon_cpol = 0; mon_cpha = 0; mon_cnt = 0; mon_raw = '0;
      wr(4'h3, 32'h0C01_00A5);
      wait_eoq();
      chk("R2 bit count", mon_cnt, 8);
      chk("R2 msb-first data", {16'b0, mon_raw} & 32'hFF, 32'hA5);
      rd(4'h4, d); chk("R5 pop data", d, 32'hA5);
      rd(4'h1, d); chk("R8 count after clear", {16'b0, d[31:16]}, 32'd1);
      chk("R6 irq masked", {31'b0, irq}, 32'd0);
      wr(4'h2, 32'h1);
      chk("R6 irq enabled", {31'b0, irq}, 32'd1);
      wr(4'h1, 32'h1);
      chk("R6 irq after w1c", {31'b0, irq}, 32'd0);
      wr(4'h2, 32'h0);
   endtask

   task automatic t_mode3_lsb();
      logic [31:0] d;
      wr(4'h9, 32'h17B);
      mon_cpol = 1; mon_cpha = 1; mon_cnt = 0; mon_raw = '0; inv = 1'b1;
      wr(4'h3, 32'h1801_03C6);
      wait_eoq();
      chk("R3 bit count mode3", mon_cnt, 12);
      chk("R4 lsb-first order", {16'b0, mon_raw} & 32'hFFF, {16'b0, rev(16'h03C6, 12)});
      rd(4'h4, d); chk("R5 inverted capture lsb", d, 32'hC39);
      chk("R3 sck rests at polarity 1", {31'b0, sck_o}, 32'd1);
      wr(4'h1, 32'h1);
      inv = 1'b0;
      mon_cpol = 0; mon_cpha = 0;
   endtask

   task automatic t_halt();
      logic [31:0] d;
      wr(4'h0, 32'h3F00);
      mon_cnt = 0;
      wr(4'h3, 32'h0801_0011);
      wr(4'h3, 32'h0C01_0022);
      wr(4'h0, 32'h3F01);
      wait_eoq();
      repeat (40) @(posedge clk);
      rd(4'h1, d);
      chk("R6 queue halted level", {28'b0, d[7:4]}, 32'd1);
      chk("R8 count three frames", {16'b0, d[31:16]}, 32'd3);
      chk("R6 only one frame ran", mon_cnt, 8);
      wr(4'h1, 32'h1);
      wait_eoq();
      rd(4'h1, d); chk("R8 clear then count", {16'b0, d[31:16]}, 32'd1);
      rd(4'h4, d); chk("R5 oldest first", d, 32'h11);
      rd(4'h4, d); chk("R5 second entry", d, 32'h22);
      wr(4'h1, 32'h1);
   endtask

   task automatic t_cont();
      int a0;
      a0 = mon_asserts;
      wr(4'h3, 32'h8001_0055);
      wr(4'h3, 32'h0801_0066);
      wait_eoq();
      chk("R7 held select one assertion", mon_asserts - a0, 1);
      chk("R7 select released", {26'b0, cs_o}, 32'h3F);
      wr(4'h1, 32'h1);
      a0 = mon_asserts;
      wr(4'h3, 32'h0001_0077);
      wr(4'h3, 32'h0801_0088);
      wait_eoq();
      chk("R7 separate assertions", mon_asserts - a0, 2);
      wr(4'h1, 32'h1);
      wr(4'h0, 32'h2_3F01);
   endtask

   task automatic t_errors();
      logic [31:0] d;
      wr(4'h0, 32'h3F00);
      mon_cnt = 0;
      for (int i = 0; i < 5; i++) wr(4'h3, 32'h0001_0000 + i);
      rd(4'h1, d);
      chk("R9 full level", {28'b0, d[7:4]}, 32'd4);
      chk("R9 overflow error", {31'b0, d[1]}, 32'd1);
      repeat (40) @(posedge clk);
      chk("R11 no frame while stopped", mon_cnt, 0);
      rd(4'h1, d); chk("R11 queue kept", {28'b0, d[7:4]}, 32'd4);
      wr(4'h1, 32'h2);
      rd(4'h1, d); chk("R9 error cleared", {31'b0, d[1]}, 32'd0);
      rd(4'h4, d);
      rd(4'h1, d);
      chk("R9 underflow error", {31'b0, d[1]}, 32'd1);
      chk("R9 rx level stays 0", {28'b0, d[11:8]}, 32'd0);
      wr(4'h1, 32'h2);
   endtask

   task automatic t_flush();
      logic [31:0] d;
      wr(4'h0, 32'h1_3F00);
      rd(4'h1, d); chk("R10 tx flushed", {28'b0, d[7:4]}, 32'd0);
      rd(4'h0, d); chk("R10 flush bits read 0", d, 32'h3F00);
      wr(4'h0, 32'h3F01);
      wr(4'h3, 32'h0001_0001);
      wr(4'h3, 32'h0801_0002);
      wait_eoq();
      rd(4'h1, d); chk("R5 rx level two", {28'b0, d[11:8]}, 32'd2);
      wr(4'h0, 32'h2_3F01);
      rd(4'h1, d); chk("R10 rx flushed", {28'b0, d[11:8]}, 32'd0);
      wr(4'h1, 32'h1);
   endtask

   task automatic t_short();
      logic [31:0] d;
      wr(4'h8, 32'h1);
      mon_cnt = 0; mon_raw = '0;
      wr(4'h3, 32'h0801_000B);
      wait_eoq();
      chk("R2 short length clamps to 4", mon_cnt, 4);
      chk("R2 4-bit data", {16'b0, mon_raw} & 32'hF, 32'hB);
      rd(4'h4, d); chk("R5 4-bit capture", d, 32'hB);
      wr(4'h1, 32'h1);
      wr(4'h8, 32'h7);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      mon_cnt = 0;
      wr(4'h3, 32'h0801_00C3);
      wait (mon_cnt == 8);
      reg_wr = 1'b1; reg_addr = 4'h1; reg_wdata = 32'h1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
      rd(4'h1, d); chk("R6 set wins over same-cycle clear", {31'b0, d[0]}, 32'd1);
      wr(4'h1, 32'h1);
      rd(4'h1, d); chk("R6 later clear works", {31'b0, d[0]}, 32'd0);
      rd(4'h4, d); chk("R5 collide frame data", d, 32'hC3);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_basic();
      t_mode3_lsb();
      t_halt();
      t_cont();
      t_errors();
      t_flush();
      t_short();
      t_collide();
      summary();
      $finish;
   end
endmodule